// File: doc/BRIEF.md
# Sparse Column Multiply-Accumulate Walker

This block is the datapath of one processing element for a sparse matrix times vector product. The weight matrix is stored column by column in compressed form. For each requested column, a pointer table gives where that column's entries start and end in an entry memory. The block streams those entries one per cycle. Each entry carries a 4-bit weight code and a 4-bit row skip. The code is turned into a signed 16-bit weight through a small loadable codebook. The product of that weight and the column's activation is added into the row accumulator the entry selects.

A column request is a valid/ready transfer of a column index and a 16-bit signed activation. The block takes a request only in a cycle where both `in_valid` and `in_ready` are high. `in_ready` stays low while a column is being fetched and walked. A source that holds `in_valid` high during that time is simply kept waiting, and its request is not taken. The accumulators keep running sums across columns until reset. A single load port fills the codebook, the column pointer table and the entry memory.

The column pointers are split across two banks by the parity of the pointer index. Because of this split, the start and end bounds of any column come out of one read cycle. The codebook lookup has its own pipeline stage, so it costs no throughput.

Top module: `spw_sparse_col_mac`

## Requirements
- R1: After reset every accumulator reads zero and `in_ready` is high.
- R2: A request is taken only when `in_valid` and `in_ready` are both high. A request held on `in_valid` while `in_ready` is low has no effect on any accumulator.
- R3: Column c covers the entries at addresses p[c] up to but not including p[c+1]. Each of these entries is applied exactly once, and no other entry is applied.
- R4: Pointer index k is written through the load port with `ld_sel`=1 and `ld_addr`=k. Even indices go to one bank and odd indices to the other. The start bound of column c comes from the bank picked by the parity of c. The end bound comes from the bank picked by the parity of c+1.
- R5: An entry byte holds the weight code in bits [7:4] and the row skip in bits [3:0]. A row cursor is cleared at the start of each column. Each entry targets row = cursor + skip, and the cursor then becomes that row + 1.
- R6: An entry with code 0 and skip 15 is padding. It changes no accumulator but still advances the cursor, by 16.
- R7: The codebook maps a code to a signed 16-bit weight and is written with `ld_sel`=0 (`ld_addr`[3:0] = code). Each applied entry adds weight times activation, signed, to its 32-bit accumulator with two's-complement wrap. A reloaded codebook takes effect for later columns.
- R8: A column whose start and end bounds are equal changes no accumulator. For such a column `in_ready` is low for exactly one cycle after acceptance.
- R9: An entry whose target row is at or beyond the accumulator count changes no accumulator.
- R10: A column with N>0 entries keeps `in_ready` low for exactly N+1 cycles after acceptance: one cycle for the pointer read, then one cycle per entry.
- R11: Entry bytes are written with `ld_sel`=2 and `ld_addr` = entry address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Column request valid |
| in_ready | output | 1 | Block can take a column request |
| in_col | input | COL_W (3) | Column index |
| in_act | input | ACT_W (16) | Signed activation for the column |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 2 | Load target: 0 codebook, 1 pointer, 2 entry |
| ld_addr | input | LD_AW (8) | Load address |
| ld_data | input | LD_DW (16) | Load data |
| acc_flat | output | NUM_ROWS*ACC_W (1024) | All accumulators, row r at bits [r*32 +: 32] |

## Verification
The bench sweeps every column under four activations: zero, the most positive value, minus one and the most negative value. The zero activation separates entry-walk errors from arithmetic errors. The two extreme values expose sign-extension and wrap faults in the product and the sum. The pointer table holds an empty column, a one-entry column, columns of both parities and a column whose rows run past the accumulator count. These tell apart bank-parity mistakes, off-by-one bounds and missing range checks. Hand-placed padding entries and a reloaded codebook show that padding moves only the cursor and that the lookup follows the loaded table. A request held on the input while the block is busy shows that nothing is taken outside the handshake.

// File: rtl/spw_pkg.sv
package spw_pkg;
  localparam int CODE_W   = 4;
  localparam int SKIP_W   = 4;
  localparam int ENTRY_W  = CODE_W + SKIP_W;
  localparam int CB_DEPTH = 1 << CODE_W;

  localparam logic [1:0] LD_CODEBOOK = 2'd0;
  localparam logic [1:0] LD_POINTER  = 2'd1;
  localparam logic [1:0] LD_ENTRY    = 2'd2;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_FETCH = 2'd1,
    WS_WALK  = 2'd2
  } walk_state_e;
endpackage

// File: rtl/spw_ptr_banks.sv
module spw_ptr_banks #(
  parameter int NUM_COLS = 8,
  parameter int PTR_W    = 7,
  parameter int LD_AW    = 8,
  parameter int LD_DW    = 16
) (
  input  logic                        clk,
  input  logic                        ld_en,
  input  logic [1:0]                  ld_sel,
  input  logic [LD_AW-1:0]            ld_addr,
  input  logic [LD_DW-1:0]            ld_data,
  input  logic                        rd_en,
  input  logic [$clog2(NUM_COLS)-1:0] rd_col,
  output logic [PTR_W-1:0]            start_ptr,
  output logic [PTR_W-1:0]            end_ptr
);
  import spw_pkg::*;

  localparam int COL_W  = $clog2(NUM_COLS);
  localparam int BANK_D = NUM_COLS / 2 + 1;
  localparam int BA_W   = (BANK_D > 1) ? $clog2(BANK_D) : 1;

  logic [COL_W:0]               col_ext;
  logic [COL_W:0]               col_nxt;
  logic [1:0][BA_W-1:0]         bank_ra;
  logic [1:0][PTR_W-1:0]        bank_q;
  logic                         par_q;

  // Bank 0 holds even pointer indices, bank 1 odd ones. The even bank is
  // read at (c+1)>>1 and the odd bank at c>>1, so for any column the two
  // bounds sit in different banks.
  assign col_ext    = {1'b0, rd_col};
  assign col_nxt    = col_ext + {{COL_W{1'b0}}, 1'b1};
  assign bank_ra[0] = BA_W'(col_nxt >> 1);
  assign bank_ra[1] = BA_W'(col_ext >> 1);

  generate
    for (genvar g = 0; g < 2; g++) begin : g_bank
      logic [PTR_W-1:0] mem [BANK_D];
      logic [PTR_W-1:0] q;
      always_ff @(posedge clk) begin
        if (ld_en && ld_sel == LD_POINTER && ld_addr[0] == 1'(g))
          mem[ld_addr[BA_W:1]] <= ld_data[PTR_W-1:0];
        if (rd_en)
          q <= mem[bank_ra[g]];
      end
      assign bank_q[g] = q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rd_en) par_q <= rd_col[0];
  end

  assign start_ptr = par_q ? bank_q[1] : bank_q[0];
  assign end_ptr   = par_q ? bank_q[0] : bank_q[1];
endmodule

// File: rtl/spw_walker.sv
module spw_walker #(
  parameter int NUM_COLS    = 8,
  parameter int ENTRY_DEPTH = 64,
  parameter int PTR_W       = 7,
  parameter int ACT_W       = 16,
  parameter int LD_AW       = 8,
  parameter int LD_DW       = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [$clog2(NUM_COLS)-1:0] in_col,
  input  logic [ACT_W-1:0]            in_act,
  input  logic                        ld_en,
  input  logic [1:0]                  ld_sel,
  input  logic [LD_AW-1:0]            ld_addr,
  input  logic [LD_DW-1:0]            ld_data,
  output logic                        iss_valid,
  output logic                        iss_first,
  output logic [spw_pkg::ENTRY_W-1:0] iss_entry,
  output logic [ACT_W-1:0]            iss_act
);
  import spw_pkg::*;

  localparam int EA_W = $clog2(ENTRY_DEPTH);
  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

  walk_state_e        state;
  logic [PTR_W-1:0]   rd_addr;
  logic [PTR_W-1:0]   rd_next;
  logic [PTR_W-1:0]   start_ptr;
  logic [PTR_W-1:0]   end_ptr;
  logic [ACT_W-1:0]   act_q;
  logic               first_q;
  logic               accept;
  logic [ENTRY_W-1:0] entry_mem [ENTRY_DEPTH];

  assign in_ready = (state == WS_IDLE);
  assign accept   = in_valid && in_ready;
  assign rd_next  = rd_addr + PTR_ONE;

  spw_ptr_banks #(
    .NUM_COLS (NUM_COLS),
    .PTR_W    (PTR_W),
    .LD_AW    (LD_AW),
    .LD_DW    (LD_DW)
  ) ptr_i (
    .clk       (clk),
    .ld_en     (ld_en),
    .ld_sel    (ld_sel),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .rd_en     (accept),
    .rd_col    (in_col),
    .start_ptr (start_ptr),
    .end_ptr   (end_ptr)
  );

  always_ff @(posedge clk) begin
    if (ld_en && ld_sel == LD_ENTRY)
      entry_mem[ld_addr[EA_W-1:0]] <= ld_data[ENTRY_W-1:0];
    if (state == WS_WALK)
      iss_entry <= entry_mem[rd_addr[EA_W-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= WS_IDLE;
      rd_addr   <= '0;
      act_q     <= '0;
      first_q   <= 1'b0;
      iss_valid <= 1'b0;
      iss_first <= 1'b0;
      iss_act   <= '0;
    end else begin
      iss_valid <= 1'b0;
      unique case (state)
        WS_IDLE: begin
          if (accept) begin
            act_q <= in_act;
            state <= WS_FETCH;
          end
        end
        WS_FETCH: begin
          rd_addr <= start_ptr;
          first_q <= 1'b1;
          state   <= (start_ptr == end_ptr) ? WS_IDLE : WS_WALK;
        end
        WS_WALK: begin
          iss_valid <= 1'b1;
          iss_first <= first_q;
          iss_act   <= act_q;
          first_q   <= 1'b0;
          rd_addr   <= rd_next;
          if (rd_next == end_ptr) state <= WS_IDLE;
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

  // R2: a taken request closes the handshake for the next cycle.
  assert_busy_after_accept_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R3: the read address never reaches the end bound while walking.
  assert_addr_in_bounds_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    (state == WS_WALK) |-> (rd_addr < end_ptr));

  // R10: one entry address per cycle until the last one.
  assert_walk_step_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
    (state == WS_WALK && rd_next != end_ptr) |=>
      (state == WS_WALK && rd_addr == $past(rd_addr) + PTR_ONE));
endmodule

// File: rtl/spw_decode.sv
module spw_decode #(
  parameter int NUM_ROWS = 32,
  parameter int WEIGHT_W = 16,
  parameter int ACT_W    = 16,
  parameter int LD_AW    = 8,
  parameter int LD_DW    = 16,
  parameter int CUR_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ld_en,
  input  logic [1:0]                  ld_sel,
  input  logic [LD_AW-1:0]            ld_addr,
  input  logic [LD_DW-1:0]            ld_data,
  input  logic                        e_valid,
  input  logic                        e_first,
  input  logic [spw_pkg::ENTRY_W-1:0] e_entry,
  input  logic [ACT_W-1:0]            e_act,
  output logic                        m_valid,
  output logic [$clog2(NUM_ROWS)-1:0] m_row,
  output logic [WEIGHT_W-1:0]         m_w,
  output logic [ACT_W-1:0]            m_act
);
  import spw_pkg::*;

  localparam int ROW_W = $clog2(NUM_ROWS);
  localparam logic [CUR_W-1:0] ROWS_C  = CUR_W'(NUM_ROWS);
  localparam logic [CUR_W-1:0] CUR_ONE = CUR_W'(1);

  logic [WEIGHT_W-1:0] codebook [CB_DEPTH];
  logic [CODE_W-1:0]   e_code;
  logic [SKIP_W-1:0]   e_skip;
  logic                e_pad;
  logic [CUR_W-1:0]    cursor;
  logic [CUR_W-1:0]    base;
  logic [CUR_W-1:0]    target;
  logic                in_range;

  assign e_code   = e_entry[ENTRY_W-1:SKIP_W];
  assign e_skip   = e_entry[SKIP_W-1:0];
  assign e_pad    = (e_code == '0) && (e_skip == '1);
  assign base     = e_first ? '0 : cursor;
  assign target   = base + CUR_W'(e_skip);
  assign in_range = target < ROWS_C;

  // Codebook lookup is its own registered stage.
  always_ff @(posedge clk) begin
    if (ld_en && ld_sel == LD_CODEBOOK)
      codebook[ld_addr[CODE_W-1:0]] <= ld_data[WEIGHT_W-1:0];
    if (e_valid) begin
      m_w   <= codebook[e_code];
      m_row <= target[ROW_W-1:0];
      m_act <= e_act;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cursor  <= '0;
      m_valid <= 1'b0;
    end else begin
      m_valid <= e_valid && !e_pad && in_range;
      if (e_valid) cursor <= target + CUR_ONE;
    end
  end

  // R6: a padding entry never reaches the multiply-accumulate stage.
  assert_pad_no_mac_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    (e_valid && e_pad) |=> !m_valid);

  // R5: the first entry of a column lands on its own skip value.
  assert_cursor_restart_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    (e_valid && e_first && !e_pad && CUR_W'(e_skip) < ROWS_C) |=>
      (m_valid && CUR_W'(m_row) == CUR_W'($past(e_skip))));
endmodule

// File: rtl/spw_acc_bank.sv
module spw_acc_bank #(
  parameter int NUM_ROWS = 32,
  parameter int WEIGHT_W = 16,
  parameter int ACT_W    = 16,
  parameter int ACC_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        m_valid,
  input  logic [$clog2(NUM_ROWS)-1:0] m_row,
  input  logic [WEIGHT_W-1:0]         m_w,
  input  logic [ACT_W-1:0]            m_act,
  output logic [NUM_ROWS*ACC_W-1:0]   acc_flat
);
  localparam int PROD_W = WEIGHT_W + ACT_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;

  assign prod     = $signed(m_w) * $signed(m_act);
  assign prod_ext = ACC_W'(prod);

  generate
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      logic [ACC_W-1:0] acc;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          acc <= '0;
        else if (m_valid && m_row == r[$clog2(NUM_ROWS)-1:0])
          acc <= acc + prod_ext;
      end
      assign acc_flat[r*ACC_W +: ACC_W] = acc;
    end
  endgenerate

  // R3: no accumulator moves without an applied entry.
  assert_acc_hold_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    !m_valid |=> $stable(acc_flat));
endmodule

// File: rtl/spw_sparse_col_mac.sv
module spw_sparse_col_mac #(
  parameter int NUM_ROWS    = 32,
  parameter int NUM_COLS    = 8,
  parameter int ENTRY_DEPTH = 64,
  parameter int WEIGHT_W    = 16,
  parameter int ACT_W       = 16,
  parameter int ACC_W       = 32,
  parameter int LD_AW       = 8,
  parameter int LD_DW       = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [$clog2(NUM_COLS)-1:0] in_col,
  input  logic [ACT_W-1:0]            in_act,
  input  logic                        ld_en,
  input  logic [1:0]                  ld_sel,
  input  logic [LD_AW-1:0]            ld_addr,
  input  logic [LD_DW-1:0]            ld_data,
  output logic [NUM_ROWS*ACC_W-1:0]   acc_flat
);
  import spw_pkg::*;

  localparam int PTR_W = $clog2(ENTRY_DEPTH + 1);
  localparam int ROW_W = $clog2(NUM_ROWS);

  logic               iss_valid;
  logic               iss_first;
  logic [ENTRY_W-1:0] iss_entry;
  logic [ACT_W-1:0]   iss_act;
  logic               m_valid;
  logic [ROW_W-1:0]   m_row;
  logic [WEIGHT_W-1:0] m_w;
  logic [ACT_W-1:0]   m_act;

  spw_walker #(
    .NUM_COLS    (NUM_COLS),
    .ENTRY_DEPTH (ENTRY_DEPTH),
    .PTR_W       (PTR_W),
    .ACT_W       (ACT_W),
    .LD_AW       (LD_AW),
    .LD_DW       (LD_DW)
  ) walk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_col    (in_col),
    .in_act    (in_act),
    .ld_en     (ld_en),
    .ld_sel    (ld_sel),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .iss_valid (iss_valid),
    .iss_first (iss_first),
    .iss_entry (iss_entry),
    .iss_act   (iss_act)
  );

  spw_decode #(
    .NUM_ROWS (NUM_ROWS),
    .WEIGHT_W (WEIGHT_W),
    .ACT_W    (ACT_W),
    .LD_AW    (LD_AW),
    .LD_DW    (LD_DW),
    .CUR_W    (16)
  ) dec_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (ld_en),
    .ld_sel  (ld_sel),
    .ld_addr (ld_addr),
    .ld_data (ld_data),
    .e_valid (iss_valid),
    .e_first (iss_first),
    .e_entry (iss_entry),
    .e_act   (iss_act),
    .m_valid (m_valid),
    .m_row   (m_row),
    .m_w     (m_w),
    .m_act   (m_act)
  );

  spw_acc_bank #(
    .NUM_ROWS (NUM_ROWS),
    .WEIGHT_W (WEIGHT_W),
    .ACT_W    (ACT_W),
    .ACC_W    (ACC_W)
  ) acc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_valid  (m_valid),
    .m_row    (m_row),
    .m_w      (m_w),
    .m_act    (m_act),
    .acc_flat (acc_flat)
  );
endmodule

// File: tb/spw_sparse_col_mac_tb.sv
`timescale 1ns/1ps
module spw_sparse_col_mac_tb_top;
  localparam int NR = 32;
  localparam int NC = 8;
  localparam int ND = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [2:0]        in_col = '0;
  logic [15:0]       in_act = '0;
  logic              ld_en = 1'b0;
  logic [1:0]        ld_sel = '0;
  logic [7:0]        ld_addr = '0;
  logic [15:0]       ld_data = '0;
  logic [NR*32-1:0]  acc_flat;

  int errors = 0;
  int checks = 0;

  logic signed [15:0] cb   [16];
  logic [7:0]         ent  [ND];
  int                 ptrs [NC+1];
  logic signed [31:0] expv [NR];

  always #4 clk = ~clk;

  spw_sparse_col_mac dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_col(in_col), .in_act(in_act), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_addr(ld_addr), .ld_data(ld_data), .acc_flat(acc_flat)
  );

  task automatic load(input logic [1:0] sel, input int addr, input logic [15:0] data);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_addr = 8'(addr); ld_data = data;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_accs(input string tag);
    int bad = -1;
    checks++;
    for (int r = 0; r < NR; r++)
      if (bad < 0 && acc_flat[r*32 +: 32] !== expv[r]) bad = r;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s row %0d actual=%0d expected=%0d", tag, bad,
               $signed(acc_flat[bad*32 +: 32]), expv[bad]);
    end
  endtask

  task automatic model_col(input int c, input logic signed [15:0] act);
    int cur = 0;
    for (int i = ptrs[c]; i < ptrs[c+1]; i++) begin
      int code = int'(ent[i][7:4]);
      int skip = int'(ent[i][3:0]);
      int t = cur + skip;
      cur = t + 1;
      if (!(code == 0 && skip == 15) && t < NR)
        expv[t] = expv[t] + 32'(cb[code] * act);
    end
  endtask

  task automatic load_codebook(input int set);
    for (int k = 0; k < 16; k++) begin
      if (set == 0)
        cb[k] = (k == 14) ? 16'sd32767 : (k == 15) ? -16'sd32768 : 16'(k * 2311 - 13000);
      else
        cb[k] = 16'(500 - k * 1777);
      load(2'd0, k, cb[k]);
    end
  endtask

  task automatic run_col(input string tag, input int c, input logic signed [15:0] act,
                         input bit hold, input int other);
    int busy = 0;
    int n = ptrs[c+1] - ptrs[c];
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_col = 3'(c); in_act = act;
    @(posedge clk);
    #1;
    if (hold) begin in_col = 3'(other); in_act = 16'sh1234; end
    else in_valid = 1'b0;
    forever begin
      @(negedge clk);
      if (in_ready) break;
      busy++;
    end
    in_valid = 1'b0;
    model_col(c, act);
    check_int({tag, " busy R10 R8"}, busy, (n == 0) ? 1 : n + 1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check_accs(tag);
  endtask

  initial begin
    for (int r = 0; r < NR; r++) expv[r] = 0;
    ptrs = '{0, 5, 5, 12, 20, 21, 40, 52, 64};
    for (int i = 0; i < ND; i++) begin
      logic [3:0] code = 4'((i * 7 + 3) % 16);
      logic [3:0] skip = (i >= 40 && i < 52) ? 4'd3 : 4'(i % 3);
      ent[i] = {code, skip};
    end
    ent[0] = 8'h31; ent[1] = 8'h0F; ent[2] = 8'hF2; ent[3] = 8'h10; ent[4] = 8'h00;
    ent[58] = 8'h0F;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check_int("R1 ready after reset", int'(in_ready), 1);
    check_accs("R1 accumulators after reset");
    rst_n = 1'b1;

    load_codebook(0);
    for (int k = 0; k <= NC; k++) load(2'd1, k, 16'(ptrs[k]));
    for (int i = 0; i < ND; i++) load(2'd2, i, {8'h00, ent[i]});

    run_col("R6 R5 R11 padding column", 0, 16'sd1000, 1'b0, 0);
    run_col("R8 empty column", 1, 16'sd5, 1'b0, 0);
    run_col("R9 rows past end", 6, 16'sd77, 1'b0, 0);
    run_col("R4 single entry odd end", 4, -16'sd300, 1'b0, 0);
    for (int a = 0; a < 4; a++) begin
      logic signed [15:0] act;
      act = (a == 0) ? 16'sd0 : (a == 1) ? 16'sd32767 : (a == 2) ? -16'sd1 : -16'sd32768;
      for (int c = 0; c < NC; c++)
        run_col("R3 R4 R5 R7 sweep", c, act, 1'b0, 0);
    end
    run_col("R2 held request ignored", 3, 16'sd211, 1'b1, 5);
    repeat (4) @(negedge clk);
    check_int("R2 ready after held request", int'(in_ready), 1);
    check_accs("R2 no extra column applied");
    load_codebook(1);
    run_col("R7 reloaded codebook", 5, -16'sd4321, 1'b0, 0);
    run_col("R7 reloaded codebook even", 2, 16'sd29999, 1'b0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule